// File: doc/BRIEF.md
# Receive Register Interface

This block is the processor side of a serial word receiver. It sits on an 8-bit bus, where one select line chooses the command space or the data space. In the command space, a write loads the control register and a read returns the status register. The control register can never be read back. In the data space, reads return received data.

The block supports two modes. In byte mode, each good byte handed over by the front end is offered on its own. In 32-bit mode, a complete good word is buffered and the host drains it with four data reads. The block keeps these flags:
- a ready flag, also driven on a pin;
- a first-byte flag;
- an overwrite flag;
- parity and framing error latches.

The control register also carries a one-shot bit that suppresses the ready flag for a single word and then clears itself.

The serial front end and any label filtering sit outside the block. They deliver byte strobes, and word-completion strobes with parity and framing verdicts.

Top module: `rx_host_regs`

## Requirements
- R1: After reset, `ctrl_o` is 0x09, the ready output is low and the status register reads 0x00. The control bits are: bit0 receive enable, bit1 ready-block, bit2 self test, bit3 parity check enable, bit4 32-bit mode.
- R2: With `cmd_sel_i` high, a write loads `ctrl_o` from `wdata_i` and a read returns status. Status bits are: bit0 ready, bit1 parity error, bit2 overwritten, bit3 framing error, bit4 first byte, and bits 7:5 read as zero. The control value is never returned on a read.
- R3: In byte mode (bit4 = 0), each accepted byte sets ready. A data read returns that byte and clears ready.
- R4: In 32-bit mode, a completed word sets ready only if it has no framing error and no parity error. Parity counts only when bit3 is set. A rejected word latches its error bits and leaves ready low.
- R5: While the ready-block bit is set, incoming data does not raise ready. The bit clears itself when the next word completes.
- R6: The first-byte flag behaves as follows:
  - In byte mode it copies the first-of-word marker of the latest accepted byte.
  - In 32-bit mode it is set by every good word, even one whose ready is blocked.
  - A draining data read clears it.
- R7: A status read clears the parity, framing and overwrite latches and leaves ready and first-byte unchanged. An error arriving in the same cycle as the clearing read stays set.
- R8: In 32-bit mode, the word is read as four data reads, least significant byte first. Ready clears after the fourth read.
- R9: New data arriving while ready is set sets the overwrite flag, and the newer data is the data kept. Data arriving in the same cycle as the final draining read does not set it.
- R10: With receive enable clear, front-end strobes change no flag and no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_sel_i | input | 1 | 1 = control/status space, 0 = data space |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during the read cycle |
| rx_byte_vld_i | input | 1 | Front end delivered a good byte |
| rx_byte_i | input | 8 | Delivered byte |
| rx_byte_first_i | input | 1 | Delivered byte is the first of its word |
| rx_word_vld_i | input | 1 | Front end completed a word |
| rx_word_i | input | 32 | Completed word |
| rx_par_err_i | input | 1 | Completed word failed parity |
| rx_frm_err_i | input | 1 | Completed word failed framing |
| ctrl_o | output | 8 | Current control register |
| rdy_o | output | 1 | Ready flag |
| first_o | output | 1 | First-byte flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the fourth draining read of a word and the arrival of the next word. The bench issues both strobes in one cycle and expects three things: ready still high, no overwrite, and the new word's low byte on the next read. The second pair is a status read and a failing word. Here the bench expects the parity latch to survive the clearing read, and it is cleared only by a following status read.

// File: rtl/rxhr_pkg.sv
package rxhr_pkg;
  localparam int C_EN   = 0;
  localparam int C_BLK  = 1;
  localparam int C_TEST = 2;
  localparam int C_PAR  = 3;
  localparam int C_M32  = 4;
  localparam logic [7:0] CTRL_RST = 8'h09;

  typedef struct packed {
    logic first;
    logic frm;
    logic ovr;
    logic par;
    logic rdy;
  } status_t;
endpackage

// File: rtl/rxhr_ctrl.sv
module rxhr_ctrl
  import rxhr_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             word_done_i,
  output logic [BUS_W-1:0] ctrl_o
);
  logic [BUS_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= BUS_W'(CTRL_RST);
    end else if (wr_ctrl_i) begin
      ctrl_q <= wdata_i;
    end else if (word_done_i) begin
      ctrl_q[C_BLK] <= 1'b0;  // one-shot block ends with the word
    end
  end

  assign ctrl_o = ctrl_q;

  AST_BLOCK_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && !wr_ctrl_i) |=> !ctrl_q[C_BLK]) else $error("blk not cleared"); // R5
endmodule

// File: rtl/rxhr_buf.sv
module rxhr_buf #(
  parameter int BUS_W      = 8,
  parameter int WORD_BYTES = 4,
  localparam int PTR_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        mode32_i,
  input  logic                        load_byte_i,
  input  logic [BUS_W-1:0]            byte_i,
  input  logic                        load_word_i,
  input  logic [WORD_BYTES*BUS_W-1:0] word_i,
  input  logic                        rd_data_i,
  output logic                        last_o,
  output logic [BUS_W-1:0]            rdata_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(WORD_BYTES - 1);

  logic [WORD_BYTES-1:0][BUS_W-1:0] word_q;
  logic [PTR_W-1:0]                 ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      ptr_q  <= '0;
    end else if (load_word_i) begin
      word_q <= word_i;
      ptr_q  <= '0;
    end else if (load_byte_i) begin
      word_q[0] <= byte_i;
      ptr_q     <= '0;
    end else if (rd_data_i && mode32_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign last_o  = (ptr_q == LAST);
  assign rdata_o = mode32_i ? word_q[ptr_q] : word_q[0];

  AST_PTR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_word_i |=> (ptr_q == '0)) else $error("ptr not restarted"); // R8
endmodule

// File: rtl/rxhr_flags.sv
module rxhr_flags
  import rxhr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    new_data_i,
  input  logic    first_in_i,
  input  logic    blk_i,
  input  logic    drain_i,
  input  logic    rd_stat_i,
  input  logic    par_hit_i,
  input  logic    frm_hit_i,
  output status_t stat_o
);
  status_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (new_data_i && !blk_i) st_d.rdy = 1'b1;
    else if (drain_i)         st_d.rdy = 1'b0;

    if (new_data_i)   st_d.first = first_in_i;
    else if (drain_i) st_d.first = 1'b0;

    if (new_data_i && st_q.rdy && !drain_i) st_d.ovr = 1'b1;
    else if (rd_stat_i)                     st_d.ovr = 1'b0;

    if (par_hit_i)      st_d.par = 1'b1;
    else if (rd_stat_i) st_d.par = 1'b0;

    if (frm_hit_i)      st_d.frm = 1'b1;
    else if (rd_stat_i) st_d.frm = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign stat_o = st_q;

  AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !par_hit_i && !frm_hit_i && !new_data_i) |=> (!st_q.par && !st_q.frm && !st_q.ovr)) else $error("latches kept"); // R7
  AST_STAT_KEEPS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !new_data_i && !drain_i) |=> $stable(st_q.rdy)) else $error("rdy moved"); // R7
  AST_OVR_ON_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_data_i && st_q.rdy && !drain_i) |=> st_q.ovr) else $error("ovr missed"); // R9
endmodule

// File: rtl/rx_host_regs.sv
module rx_host_regs
  import rxhr_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = BUS_W * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              rx_byte_vld_i,
  input  logic [BUS_W-1:0]  rx_byte_i,
  input  logic              rx_byte_first_i,
  input  logic              rx_word_vld_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  output logic [BUS_W-1:0]  ctrl_o,
  output logic              rdy_o,
  output logic              first_o
);
  logic [BUS_W-1:0] ctrl;
  logic [BUS_W-1:0] data_byte;
  logic             en, mode32, blk, par_en, last;
  logic             wr_ctrl, rd_stat, rd_data, drain;
  logic             word_done, par_hit, frm_hit, word_good, acc_byte, acc_word, new_data;
  status_t          stat;

  assign en     = ctrl[C_EN];
  assign mode32 = ctrl[C_M32];
  assign blk    = ctrl[C_BLK];
  assign par_en = ctrl[C_PAR];

  assign wr_ctrl = wr_i && cmd_sel_i;
  assign rd_stat = rd_i && cmd_sel_i;
  assign rd_data = rd_i && !cmd_sel_i;
  assign drain   = rd_data && (!mode32 || last);

  assign word_done = en && rx_word_vld_i;
  assign par_hit   = word_done && rx_par_err_i && par_en;
  assign frm_hit   = word_done && rx_frm_err_i;
  assign word_good = word_done && !par_hit && !frm_hit;
  assign acc_word  = word_good && mode32;
  assign acc_byte  = en && rx_byte_vld_i && !mode32;
  assign new_data  = acc_word || acc_byte;

  rxhr_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_ctrl),
    .wdata_i    (wdata_i),
    .word_done_i(word_done),
    .ctrl_o     (ctrl)
  );

  rxhr_buf #(.BUS_W(BUS_W), .WORD_BYTES(WORD_BYTES)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode32_i   (mode32),
    .load_byte_i(acc_byte),
    .byte_i     (rx_byte_i),
    .load_word_i(acc_word),
    .word_i     (rx_word_i),
    .rd_data_i  (rd_data),
    .last_o     (last),
    .rdata_o    (data_byte)
  );

  rxhr_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .new_data_i(new_data),
    .first_in_i(mode32 ? 1'b1 : rx_byte_first_i),
    .blk_i     (blk),
    .drain_i   (drain),
    .rd_stat_i (rd_stat),
    .par_hit_i (par_hit),
    .frm_hit_i (frm_hit),
    .stat_o    (stat)
  );

  assign rdata_o = cmd_sel_i ? BUS_W'(stat) : data_byte;
  assign ctrl_o  = ctrl;
  assign rdy_o   = stat.rdy;
  assign first_o = stat.first;

  AST_RDY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && mode32 && last && !new_data) |=> !rdy_o) else $error("rdy after drain"); // R8
  AST_FIRST_ON_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_word |=> first_o) else $error("first missing"); // R6
  AST_BLOCKED_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_data && blk && !rdy_o) |=> !rdy_o) else $error("blocked rdy"); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !rd_i && !wr_i) |=> $stable(stat)) else $error("disabled moved"); // R10
endmodule

// File: tb/rx_host_regs_bench.sv
`timescale 1ns/1ps
module rx_host_regs_bench;
  logic        clk = 0, rst_ni = 0;
  logic        cmd_sel = 0, rd = 0, wr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic        byte_vld = 0, byte_first = 0, word_vld = 0, par_err = 0, frm_err = 0;
  logic [7:0]  rx_byte = 0;
  logic [31:0] rx_word = 0;
  logic [7:0]  ctrl;
  logic        rdy, first;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  rx_host_regs u_rx_host_regs (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_sel_i(cmd_sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_byte_vld_i(byte_vld), .rx_byte_i(rx_byte),
    .rx_byte_first_i(byte_first), .rx_word_vld_i(word_vld), .rx_word_i(rx_word),
    .rx_par_err_i(par_err), .rx_frm_err_i(frm_err), .ctrl_o(ctrl), .rdy_o(rdy), .first_o(first)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cmd_sel = sel; wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] d);
    @(negedge clk); cmd_sel = sel; rd = 1;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic send_word(input logic [31:0] w, input logic pe, input logic fe);
    @(negedge clk); word_vld = 1; rx_word = w; par_err = pe; frm_err = fe;
    @(negedge clk); word_vld = 0; par_err = 0; frm_err = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic f);
    @(negedge clk); byte_vld = 1; rx_byte = b; byte_first = f;
    @(negedge clk); byte_vld = 0; byte_first = 0;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 ctrl", ctrl, 8'h09);
    check("R1 rdy", rdy, 0);
    bus_rd(1, s); check("R1 status", s, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] s;
    bus_wr(1, 8'h1D); check("R2 ctrl load", ctrl, 8'h1D);
    bus_rd(1, s);     check("R2 ctrl not readable", s, 8'h00);
    bus_wr(1, 8'h19); check("R2 ctrl reload", ctrl, 8'h19);
  endtask

  task automatic t_word32();
    logic [7:0] s, d;
    send_word(32'hA1B2C3D4, 0, 0);
    check("R4 rdy on good word", rdy, 1);
    bus_rd(1, s); check("R2 status layout", s, 8'h11);
    bus_rd(0, d); check("R8 byte0", d, 8'hD4);
    bus_rd(0, d); check("R8 byte1", d, 8'hC3);
    bus_rd(0, d); check("R8 byte2", d, 8'hB2);
    check("R8 rdy held", rdy, 1);
    bus_rd(0, d); check("R8 byte3", d, 8'hA1);
    check("R8 rdy cleared", rdy, 0);
    check("R6 first cleared", first, 0);
  endtask

  task automatic drain4();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) bus_rd(0, d);
  endtask

  task automatic t_errors();
    logic [7:0] s;
    send_word(32'h11111111, 1, 0);
    check("R4 parity rejects", rdy, 0);
    bus_rd(1, s); check("R4 parity latched", s, 8'h02);
    bus_rd(1, s); check("R7 status read clears", s, 8'h00);
    send_word(32'h22222222, 0, 1);
    bus_rd(1, s); check("R4 framing latched", s, 8'h08);
    bus_wr(1, 8'h11);
    send_word(32'h33333333, 1, 0);
    check("R4 parity ignored when off", rdy, 1);
    drain4();
    bus_wr(1, 8'h19);
  endtask

  task automatic t_block();
    logic [7:0] s;
    bus_wr(1, 8'h1B); check("R5 blk set", ctrl[1], 1);
    send_word(32'h0000005A, 0, 0);
    check("R5 rdy suppressed", rdy, 0);
    check("R5 blk self-clear", ctrl[1], 0);
    bus_rd(1, s); check("R6 first despite block", s, 8'h10);
    send_word(32'h0000006B, 0, 0);
    check("R5 next word ready", rdy, 1);
    drain4();
  endtask

  task automatic t_overrun();
    logic [7:0] s, d;
    send_word(32'h44332211, 0, 0);
    send_word(32'h88776655, 0, 0);
    bus_rd(1, s); check("R9 overwrite flagged", s, 8'h15);
    bus_rd(1, s); check("R7 rdy kept ovr cleared", s, 8'h11);
    bus_rd(0, d); check("R9 newer word kept", d, 8'h55);
    bus_rd(0, d); bus_rd(0, d); bus_rd(0, d);
  endtask

  task automatic t_collide();
    logic [7:0] s, d;
    send_word(32'hDDCCBBAA, 0, 0);
    bus_rd(0, d); bus_rd(0, d); bus_rd(0, d);
    @(negedge clk); cmd_sel = 0; rd = 1; word_vld = 1; rx_word = 32'h0403020F;
    #1 d = rdata;
    @(negedge clk); rd = 0; word_vld = 0;
    check("R8 last byte on collide", d, 8'hDD);
    bus_rd(1, s); check("R9 no overwrite at drain", s, 8'h11);
    bus_rd(0, d); check("R9 new word low byte", d, 8'h0F);
    bus_rd(0, d); bus_rd(0, d); bus_rd(0, d);
  endtask

  task automatic t_stat_same();
    logic [7:0] s;
    @(negedge clk); cmd_sel = 1; rd = 1; word_vld = 1; par_err = 1;
    #1 s = rdata;
    @(negedge clk); rd = 0; word_vld = 0; par_err = 0;
    bus_rd(1, s); check("R7 error survives clear", s, 8'h02);
    bus_rd(1, s); check("R7 cleared later", s, 8'h00);
  endtask

  task automatic t_byte();
    logic [7:0] s, d;
    bus_wr(1, 8'h09);
    send_byte(8'h5A, 1);
    check("R3 byte ready", rdy, 1);
    bus_rd(1, s); check("R6 first byte", s, 8'h11);
    bus_rd(0, d); check("R3 byte data", d, 8'h5A);
    check("R3 ready cleared", rdy, 0);
    send_byte(8'h33, 0);
    bus_rd(1, s); check("R6 later byte not first", s, 8'h01);
    send_byte(8'h44, 0);
    bus_rd(1, s); check("R9 byte overwrite", s, 8'h05);
    bus_rd(0, d); check("R9 newer byte", d, 8'h44);
  endtask

  task automatic t_disable();
    logic [7:0] s, d;
    bus_wr(1, 8'h18);
    send_word(32'hCAFEF00D, 1, 1);
    send_byte(8'h77, 1);
    check("R10 rdy unchanged", rdy, 0);
    bus_rd(1, s); check("R10 status unchanged", s, 8'h00);
    bus_rd(0, d); check("R10 data unchanged", d, 8'h44);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_word32();
    t_errors();
    t_block();
    t_overrun();
    t_collide();
    t_stat_same();
    t_byte();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule